// File: doc/BRIEF.md
# Malformed TLP Request Checker

This block sits behind the header parser of a PCI Express receive path. For every parsed request header it applies two malformation rules and decides whether the packet may go on to the application side. Memory read and memory write requests must not run past the end of the 4 KB page where they start. Message requests must travel on traffic class 0. Every other packet kind is forwarded unchecked.

The parser presents one header per cycle on a strobe. Exactly one cycle later the checker reports a verdict: either forward, or drop together with a one-cycle fatal uncorrectable error pulse. A dropped packet never reaches the application. Raising the error message toward the root complex, buffering the payload and parsing the header are handled elsewhere.

Top module: `tlp_malform_chk`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `hdr_valid` is high, and low in the cycle after each cycle in which it is low.
- R2: A memory request (`hdr_type` = 5'b00000 with `hdr_fmt` 3'b000, 3'b001, 3'b010 or 3'b011) is dropped when `hdr_addr[11:0]` plus its byte count minus one exceeds 0xFFF. The byte count is four times the length field. A request ending exactly at 0xFFF is forwarded.
- R3: A length field of 0 means 1024 DWORDs (4096 bytes). Such a request is forwarded only when `hdr_addr[11:0]` is 0.
- R4: The boundary rule applies to nothing but memory requests. I/O (type 5'b00010), configuration (type 5'b00100) and completion (type 5'b01010) packets are forwarded whatever their address and length.
- R5: A message (`hdr_fmt[0]` = 1, `hdr_fmt[2]` = 0, `hdr_type[4:3]` = 2'b10) with a nonzero `hdr_tc` is dropped. A message on class 0 is forwarded, and messages are exempt from the boundary rule.
- R6: On a verdict cycle, exactly one of `out_forward` and `out_drop` is high. `fatal_err` is high exactly when `out_drop` is high.
- R7: `fatal_err` is high for one cycle for each offending packet and never in a cycle that follows a cycle without a header.
- R8: While `rst` is high, every output is low in the following cycle, regardless of inputs.
- R9: The traffic-class rule does not touch memory requests. A memory request on a nonzero class that stays inside its page is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | A parsed header is present this cycle |
| hdr_fmt | input | 3 | Header format field |
| hdr_type | input | 5 | Header type field |
| hdr_tc | input | 3 | Traffic class |
| hdr_addr | input | ADDR_W (64) | Request address (low bits used) |
| hdr_len | input | LEN_W (10) | Length in DWORDs, 0 meaning 2**LEN_W |
| out_valid | output | 1 | A verdict is present this cycle |
| out_forward | output | 1 | Packet may pass to the application |
| out_drop | output | 1 | Packet is malformed and discarded |
| fatal_err | output | 1 | One-cycle fatal uncorrectable error pulse |

## Verification
The bench uses the default parameters: 64-bit address, 10-bit length and 12-bit page offset. With a 10-bit length field, the zero-length encoding spans exactly one full page. This lets the bench place requests that end on the last byte of a page and requests that spill over by a single DWORD, for both the largest and the smallest lengths. Because the page offset is 12 bits, addresses with high bits set show that only the offset within the page takes part in the check.

// File: rtl/tlp_chk_pkg.sv
package tlp_chk_pkg;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_MEM   = 2'd1,
    KIND_MSG   = 2'd2
  } pkt_kind_e;

  localparam logic [4:0] TYPE_MEM     = 5'b00000;
  localparam logic [1:0] TYPE_MSG_HI  = 2'b10;

endpackage

// File: rtl/tlp_kind_decode.sv
module tlp_kind_decode
  import tlp_chk_pkg::*;
(
  input  logic [2:0] fmt,
  input  logic [4:0] typ,
  output pkt_kind_e  kind
);

  logic is_mem;
  logic is_msg;

  always_comb begin
    // memory read/write, 3DW or 4DW, with or without data
    is_mem = (fmt[2] == 1'b0) && (typ == TYPE_MEM);
    // messages always have a 4DW header
    is_msg = (fmt[2] == 1'b0) && fmt[0] && (typ[4:3] == TYPE_MSG_HI);
    if (is_mem)      kind = KIND_MEM;
    else if (is_msg) kind = KIND_MSG;
    else             kind = KIND_OTHER;
  end

  // R4: the two classes never overlap
  always_comb begin
    assert_kind_exclusive_R4: assert (!(is_mem && is_msg));
  end

endmodule

// File: rtl/tlp_page_span.sv
module tlp_page_span #(
  parameter int PAGE_W = 12,
  parameter int LEN_W  = 10
) (
  input  logic              chk_en,
  input  logic [PAGE_W-1:0] offset,
  input  logic [LEN_W-1:0]  len_dw,
  output logic              crosses
);

  localparam int CNT_W = LEN_W + 1;
  localparam int SUM_W = PAGE_W + LEN_W + 3;
  localparam logic [SUM_W-1:0] PAGE_LAST = SUM_W'((64'd1 << PAGE_W) - 64'd1);

  logic [CNT_W-1:0] dw_count;
  logic [SUM_W-1:0] last_byte;

  always_comb begin
    dw_count  = (len_dw == '0) ? CNT_W'(64'd1 << LEN_W) : CNT_W'(len_dw);
    last_byte = SUM_W'(offset) + (SUM_W'(dw_count) << 2) - SUM_W'(1);
    crosses   = chk_en && (last_byte > PAGE_LAST);
  end

  // R3: a request starting on a page boundary never spills over
  // (holds while a full-length request fits in one page)
  always_comb begin
    if (chk_en && offset == '0 && (LEN_W + 2 <= PAGE_W)) begin
      assert_page_start_fits_R3: assert (!crosses);
    end
  end

endmodule

// File: rtl/tlp_malform_chk.sv
module tlp_malform_chk
  import tlp_chk_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 10,
  parameter int PAGE_W = 12,
  parameter int TC_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  input  logic [2:0]        hdr_fmt,
  input  logic [4:0]        hdr_type,
  input  logic [TC_W-1:0]   hdr_tc,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic [LEN_W-1:0]  hdr_len,
  output logic              out_valid,
  output logic              out_forward,
  output logic              out_drop,
  output logic              fatal_err
);

  pkt_kind_e kind;
  logic      span_bad;
  logic      tc_bad;
  logic      malformed;

  tlp_kind_decode u_kind (
    .fmt  (hdr_fmt),
    .typ  (hdr_type),
    .kind (kind)
  );

  tlp_page_span #(
    .PAGE_W (PAGE_W),
    .LEN_W  (LEN_W)
  ) u_span (
    .chk_en  (kind == KIND_MEM),
    .offset  (hdr_addr[PAGE_W-1:0]),
    .len_dw  (hdr_len),
    .crosses (span_bad)
  );

  always_comb begin
    tc_bad    = (kind == KIND_MSG) && (hdr_tc != '0);
    malformed = span_bad || tc_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_forward <= 1'b0;
      out_drop    <= 1'b0;
      fatal_err   <= 1'b0;
    end else begin
      out_valid   <= hdr_valid;
      out_forward <= hdr_valid && !malformed;
      out_drop    <= hdr_valid && malformed;
      fatal_err   <= hdr_valid && malformed;
    end
  end

  assert_verdict_follows_R1: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> out_valid);

  assert_no_spurious_verdict_R1: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> !out_valid);

  assert_msg_class_R5: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && kind == KIND_MSG && hdr_tc != '0) |=> out_drop);

  assert_drop_with_fatal_R6: assert property (@(posedge clk) disable iff (rst)
    out_drop |-> (fatal_err && out_valid && !out_forward));

  assert_one_verdict_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot({out_forward, out_drop}));

  assert_fatal_needs_header_R7: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> !fatal_err);

endmodule

// File: tb/tb_tlp_malform_chk.sv
module tb_tlp_malform_chk;

  logic        clk = 1'b0;
  logic        rst;
  logic        hdr_valid;
  logic [2:0]  hdr_fmt;
  logic [4:0]  hdr_type;
  logic [2:0]  hdr_tc;
  logic [63:0] hdr_addr;
  logic [9:0]  hdr_len;
  logic        out_valid, out_forward, out_drop, fatal_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tlp_malform_chk dut (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_fmt(hdr_fmt),
    .hdr_type(hdr_type), .hdr_tc(hdr_tc), .hdr_addr(hdr_addr),
    .hdr_len(hdr_len), .out_valid(out_valid), .out_forward(out_forward),
    .out_drop(out_drop), .fatal_err(fatal_err)
  );

  // fmt, type, tc, addr[31:0], len, expected drop
  localparam int NV = 18;
  localparam logic [53:0] VEC [0:NV-1] = '{
    {3'b000, 5'b00000, 3'd0, 32'h0000_1000, 10'd1,   1'b0}, // R2 inside page
    {3'b000, 5'b00000, 3'd0, 32'h0000_0FFC, 10'd1,   1'b0}, // R2 ends at 0xFFF
    {3'b000, 5'b00000, 3'd0, 32'h0000_0FFC, 10'd2,   1'b1}, // R2 one DW over
    {3'b011, 5'b00000, 3'd0, 32'h0000_0000, 10'd0,   1'b0}, // R3 full page
    {3'b010, 5'b00000, 3'd0, 32'h0000_0004, 10'd0,   1'b1}, // R3 full page + 4
    {3'b001, 5'b00000, 3'd0, 32'h0000_0800, 10'd512, 1'b0}, // R2 4DW read fits
    {3'b001, 5'b00000, 3'd0, 32'h0000_0804, 10'd512, 1'b1}, // R2 4DW read over
    {3'b000, 5'b00000, 3'd0, 32'h1234_5FFC, 10'd1,   1'b0}, // R2 high bits ignored
    {3'b000, 5'b00000, 3'd0, 32'h0000_1FF8, 10'd3,   1'b1}, // R2 crossing
    {3'b000, 5'b00010, 3'd0, 32'h0000_0FFC, 10'd2,   1'b0}, // R4 I/O bypass
    {3'b010, 5'b00100, 3'd0, 32'h0000_0FFC, 10'd4,   1'b0}, // R4 config bypass
    {3'b010, 5'b01010, 3'd0, 32'h0000_0FFC, 10'd0,   1'b0}, // R4 completion bypass
    {3'b001, 5'b10000, 3'd0, 32'h0000_0000, 10'd0,   1'b0}, // R5 message TC0
    {3'b001, 5'b10100, 3'd3, 32'h0000_0000, 10'd0,   1'b1}, // R5 message TC3
    {3'b011, 5'b10011, 3'd7, 32'h0000_0000, 10'd1,   1'b1}, // R5 message TC7
    {3'b001, 5'b10000, 3'd0, 32'h0000_0FFC, 10'd4,   1'b0}, // R5 no span rule
    {3'b010, 5'b00000, 3'd5, 32'h0000_0100, 10'd8,   1'b0}, // R9 TC on memory
    {3'b010, 5'b00000, 3'd1, 32'h0000_0FF0, 10'd5,   1'b1}  // R9 span still applies
  };

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {out_valid, out_forward, out_drop, fatal_err};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,fwd,drop,fatal} actual=%b expected=%b",
               req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [53:0] e);
    hdr_valid = v;
    hdr_fmt   = e[53:51];
    hdr_type  = e[50:46];
    hdr_tc    = e[45:43];
    hdr_addr  = {32'h0, e[42:11]};
    hdr_len   = e[10:1];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    // R8: reset holds every output low even with a bad header present
    rst = 1'b1;
    drive(1'b1, VEC[13]);
    repeat (3) @(negedge clk);
    check("R8 reset with header", 4'b0000);
    drive(1'b0, VEC[13]);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 after release", 4'b0000);

    // table walk: back-to-back headers, verdict one cycle later (R1, R6)
    for (int i = 0; i < NV; i++) begin
      logic d;
      d = VEC[i][0];
      drive(1'b1, VEC[i]);
      @(negedge clk);
      check($sformatf("R1/R6 vector %0d", i), {1'b1, !d, d, d});
    end

    // R7/R1: bad fields without a strobe give no verdict and no pulse
    drive(1'b0, VEC[2]);
    @(negedge clk);
    check("R7 idle after bad", 4'b0000);
    @(negedge clk);
    check("R1 idle holds", 4'b0000);

    // R7: two offending packets in a row, one pulse each, then a good one
    drive(1'b1, VEC[4]);
    @(negedge clk);
    check("R7 first pulse", 4'b1011);
    drive(1'b1, VEC[14]);
    @(negedge clk);
    check("R7 second pulse", 4'b1011);
    drive(1'b1, VEC[0]);
    @(negedge clk);
    check("R7 pulse ends on good packet", 4'b1100);
    drive(1'b0, VEC[0]);
    @(negedge clk);
    check("R7 quiet", 4'b0000);

    // R8: reset raised with an offending header in the same cycle
    rst = 1'b1;
    drive(1'b1, VEC[2]);
    @(negedge clk);
    check("R8 reset beats header", 4'b0000);
    drive(1'b0, VEC[2]);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b1, VEC[3]);
    @(negedge clk);
    check("R3 full page after reset", 4'b1100);
    drive(1'b0, VEC[3]);
    @(negedge clk);

    done = 1'b1;
    summary();
  end

endmodule